// File: doc/BRIEF.md
# Store Buffer with Read Forwarding

This block holds processor stores between a write-through cache and a slower memory. Each store is accepted on a push port in the same cycle the processor updates the cache. The entries then leave on a drain port in the order they arrived, at whatever pace the memory side accepts them. While a burst of stores is being absorbed, the push port holds off the processor once every slot is occupied.

A read that misses in the cache must not fetch a word from memory while a newer value for that address is still waiting in the buffer. The lookup port therefore compares the read address against every occupied slot at once, in the same cycle. On a match it returns the data of the youngest matching store. On no match it reports a miss, and the read may go to memory. An empty flag lets a simpler controller hold reads until the buffer has drained completely.

Top module: `wrbuf_fwd`

## Requirements
- R1: After reset the buffer holds no entries: `is_empty`=1, `dr_valid`=0, `st_ready`=1 and `rd_hit`=0.
- R2: Entries leave on the drain port in the order they were accepted. While `dr_valid` is high and `dr_ready` is low, `dr_addr` and `dr_data` hold their values.
- R3: The buffer holds DEPTH entries (4 by default). `st_ready` is low exactly when DEPTH entries are held, and a store offered while `st_ready` is low is not accepted.
- R4: If a store is accepted and an entry drains in the same cycle, the occupancy stays the same.
- R5: `rd_hit` is high in the same cycle when any held entry's address equals `rd_addr`. `rd_data` then carries that entry's data.
- R6: When several held entries match `rd_addr`, `rd_data` comes from the most recently accepted of them.
- R7: When no held entry matches, `rd_hit` is 0 and `rd_data` is 0.
- R8: An entry that is being drained in the current cycle still takes part in the match for that cycle. From the next cycle on, it no longer matches.
- R9: A store accepted in a cycle does not match in that cycle. It matches from the following cycle on.
- R10: `is_empty` is high exactly when no entries are held, and `dr_valid` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| dr_valid | output | 1 | Oldest entry available to memory |
| dr_ready | input | 1 | Memory accepts the oldest entry |
| dr_addr | output | AW | Address of the oldest entry |
| dr_data | output | DW | Data of the oldest entry |
| rd_addr | input | AW | Read lookup address |
| rd_hit | output | 1 | Some held entry matches `rd_addr` |
| rd_data | output | DW | Data of the youngest matching entry, 0 on a miss |
| is_empty | output | 1 | No entries held |

## Verification
Stores and reads use a narrow address range of eight values, so repeated addresses and multiple matches are frequent. The lookup is tried in four traffic phases: one with no draining at all, which drives the buffer full and exercises the stall, and three with increasing drain rates. A full buffer that holds a repeated address is then swept over every read address. This separates the youngest-match rule from plain hit detection and from misses. Directed sequences check the timing edges: a read in the same cycle as its store's push, and a read in the same cycle as its entry's drain. A further sequence holds a steady push-and-drain overlap, which separates correct occupancy tracking from a count that drifts.

// File: rtl/wrbuf_fwd.sv
module wrbuf_fwd #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          dr_valid,
  input  logic          dr_ready,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic          is_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic          push, pop;

  assign st_ready = (count != CW'(DEPTH));
  assign is_empty = (count == '0);
  assign dr_valid = !is_empty;
  assign dr_addr  = addr_q[head];
  assign dr_data  = data_q[head];
  assign push     = st_valid && st_ready;
  assign pop      = dr_valid && dr_ready;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= nxt(tail);
      if (pop)  head <= nxt(head);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= st_addr;
      data_q[tail] <= st_data;
    end
  end

  // oldest to youngest; a later match overrides an earlier one
  always_comb begin
    logic [PW:0] s;
    rd_hit  = 1'b0;
    rd_data = '0;
    s       = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s = {1'b0, head} + (PW+1)'(i);
      if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
      if (CW'(i) < count && addr_q[s[PW-1:0]] == rd_addr) begin
        rd_hit  = 1'b1;
        rd_data = data_q[s[PW-1:0]];
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_stall_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready && !dr_ready) |=> $stable(count));
  assert_overlap_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));
  assert_drain_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));
  assert_empty_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> (!rd_hit && rd_data == '0));
  assert_last_drain_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(1) && pop && !push) |=> is_empty);
endmodule

// File: tb/wrbuf_fwd_tb.sv
module wrbuf_fwd_tb;
  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_ready, dr_valid, dr_ready = 0, rd_hit, is_empty;
  logic [31:0] st_addr = 0, st_data = 0, dr_addr, dr_data, rd_addr = 0, rd_data;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] qa[$], qd[$];

  always #10 clk = ~clk;

  wrbuf_fwd u_dut (.clk, .rst_n, .st_valid, .st_ready, .st_addr, .st_data,
    .dr_valid, .dr_ready, .dr_addr, .dr_data, .rd_addr, .rd_hit, .rd_data, .is_empty);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit sv, input logic [31:0] sa, input logic [31:0] sd,
                      input bit drdy, input logic [31:0] ra, input string tag);
    int n, m;
    bit eh;
    logic [31:0] ed;
    string t;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; dr_ready = drdy; rd_addr = ra;
    #1;
    n = qa.size(); eh = 0; ed = 0; m = 0;
    for (int k = 0; k < n; k++)
      if (qa[k] == ra) begin eh = 1; ed = qd[k]; m++; end
    t = (tag != "") ? tag : "R3";
    chk(st_ready == (n < 4), t, "st_ready", st_ready, n < 4);
    t = (tag != "") ? tag : "R10";
    chk(is_empty == (n == 0) && dr_valid == (n != 0), t, "empty/dr_valid",
        {is_empty, dr_valid}, {n == 0, n != 0});
    if (n > 0) chk(dr_addr == qa[0] && dr_data == qd[0], (tag != "") ? tag : "R2",
                   "drain head addr", dr_addr, qa[0]);
    t = (tag != "") ? tag : (m > 1 ? "R6" : (eh ? "R5" : "R7"));
    chk(rd_hit == eh, t, "rd_hit", rd_hit, eh);
    chk(rd_data == ed, t, "rd_data", rd_data, ed);
    if (drdy && n > 0) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (sv && n < 4) begin qa.push_back(sa); qd.push_back(sd); end
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    logic [31:0] dv = 32'h1000;
    repeat (3) @(posedge clk);
    step(0, 0, 0, 0, 3, "R1");
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, "R1");
    // random traffic; phase 0 never drains, so it fills and stalls (R3)
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 600; c++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        dv++;
        step(lf[0] | lf[1], {29'd0, lf[6:4]}, dv, int'(lf[3:2]) < p, {29'd0, lf[9:7]}, "");
      end
    repeat (6) step(0, 0, 0, 1, 0, "");
    // full buffer with a repeated address, sweep every read address (R5, R6, R7)
    step(1, 2, 32'hA0, 0, 0, "");
    step(1, 5, 32'hA1, 0, 0, "");
    step(1, 2, 32'hA2, 0, 0, "");
    step(1, 7, 32'hA3, 0, 0, "");
    for (int a = 0; a < 8; a++) step(0, 0, 0, 0, a, "");
    step(1, 6, 32'hEE, 0, 2, "R3");
    repeat (5) step(0, 0, 0, 1, 0, "");
    // R4: three held, steady push and drain overlap keeps st_ready high
    step(1, 1, 32'hB0, 0, 0, "");
    step(1, 1, 32'hB1, 0, 0, "");
    step(1, 3, 32'hB2, 0, 0, "");
    for (int c = 0; c < 6; c++) step(1, 4, 32'hC0 + c, 1, 4, "R4");
    step(1, 4, 32'hCF, 0, 4, "R4");
    step(0, 0, 0, 0, 4, "R4");
    repeat (6) step(0, 0, 0, 1, 0, "");
    // R8: entry being drained still matches, then no longer
    step(1, 5, 32'hD5, 0, 5, "R9");
    step(0, 0, 0, 1, 5, "R8");
    step(0, 0, 0, 0, 5, "R8");
    // R9: a store is not visible in its own cycle, visible afterwards
    step(1, 9, 32'hD9, 0, 9, "R9");
    step(0, 0, 0, 0, 9, "R9");
    step(0, 0, 0, 1, 9, "R8");
    step(0, 0, 0, 0, 9, "R10");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule